// File: doc/BRIEF.md
# Transponder ID frame sequencer

This block produces the endless identification stream that a low-frequency tag sends once it has power. Each frame may open with a framing bit. The identification field follows, taken one bit at a time from a page-organised memory, and a closing framing bit may come after it. The frame ends with an eight-bit-time listening window in which a reader may address the tag. Every bit lasts a whole number of carrier clocks, set by a programmable rate field.

To help a reader separate several tags in the same field, the block can leave randomly chosen frames silent. A disable request silences the tag until the next reset. The outputs are the raw NRZ bit for a downstream line encoder, a strobe marking each bit boundary, a flag for an open listening window and a flag that is high throughout every frame actually sent. The memory is a plain synchronous read port: the data word for the page address arrives on the clock edge after that address.

Top module: `tag_frame_seq`

## Requirements
- R1: While reset is held, tx_bit, bit_strobe, win_open and frame_live are all 0. After reset is released, the first bit of the first frame begins on the 16th rising clock edge.
- R2: With cfg_framing=1 a frame is: one start bit, the ID bits, one stop bit, then 8 window bit times. Frames follow each other with no gap.
- R3: With cfg_framing=0 a frame is the ID bits followed directly by 8 window bit times, with no framing bits.
- R4: The ID has 32 + 8*cfg_id_len bits. ID bit k is bit (31 - k mod 32) of the word at page k/32, where k/32 is placed on mem_addr. The ID is therefore sent MSB first, from page 0 upward.
- R5: The stop bit equals cfg_stop_val and the start bit is its complement.
- R6: Every bit lasts (cfg_rate+1)*16 clocks. bit_strobe is high for exactly the first clock of each bit, and tx_bit changes only in such a clock.
- R7: In the window of a sent frame tx_bit is 0 and win_open is 1 for all 8 bit times. win_open is 0 at every other time.
- R8: With cfg_null_mode=0 every frame is sent.
- R9: With cfg_null_mode=m (1, 2 or 3), the first frame after reset is sent. After each sent frame comes a run of g silent frames, where g lies in 0..2M-1 with M = 8, 32 or 128 for m = 1, 2, 3. g is taken from a 16-bit maximal-length LFSR that is seeded at reset and steps every clock.
- R10: A one-clock pulse on disable_req lets the current frame finish unchanged. Every later frame is silent until reset.
- R11: frame_live is high from the first bit to the last window bit of each sent frame. It changes only at a frame boundary.
- R12: A silent frame lasts as long as a sent one. During it tx_bit, win_open and frame_live stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock |
| rst_n | input | 1 | Active-low reset |
| cfg_id_len | input | 4 | Extra ID bytes beyond the first four |
| cfg_framing | input | 1 | Enables the start and stop bits |
| cfg_stop_val | input | 1 | Value of the stop bit |
| cfg_rate | input | 6 | Bit period select, (value+1)*16 clocks |
| cfg_null_mode | input | 2 | Silent-frame mode: 0 none, 1/2/3 mean gaps of 8/32/128 frames |
| disable_req | input | 1 | Silences every later frame until reset |
| mem_addr | output | 3 | Page address of the next ID word |
| mem_rdata | input | 32 | Page word, valid one clock after mem_addr |
| tx_bit | output | 1 | NRZ bit to transmit |
| bit_strobe | output | 1 | High in the first clock of each bit |
| win_open | output | 1 | Listening window of a sent frame |
| frame_live | output | 1 | Current frame is being sent |

## Verification
The assertions assume that the configuration inputs hold steady outside reset. The bit-period check compares the strobe spacing with the current cfg_rate. The bench therefore changes the configuration only while reset is asserted. The assertions also assume a memory that returns the addressed word one clock later, which the bench's memory model provides. disable_req is pulsed only right after a bit strobe, well away from the next frame boundary.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  typedef enum logic [1:0] {
    PH_START = 2'd0,
    PH_ID    = 2'd1,
    PH_STOP  = 2'd2,
    PH_WIN   = 2'd3
  } tfs_phase_e;

  // Length of the silent lead-in after reset, in clocks
  localparam int LEAD_CLKS = 16;

  // Clocks per transmitted bit for a given rate field
  function automatic int unsigned bit_clocks(input int unsigned rate);
    return (rate + 1) * 16;
  endfunction

  // Number of ID bits for a given count of extra bytes
  function automatic int unsigned id_bit_count(input int unsigned base_bits,
                                               input int unsigned extra_bytes);
    return base_bits + 8 * extra_bytes;
  endfunction

  // Mask that bounds the random silent-frame count to 0 .. 2*mean-1
  function automatic int unsigned gap_mask(input int unsigned mode);
    if (mode == 0) return 0;
    return (1 << (2 * mode + 2)) - 1;
  endfunction

endpackage

// File: rtl/tfs_bit_timer.sv
module tfs_bit_timer
  import tfs_pkg::*;
#(
  parameter int RATE_W = 6,
  localparam int CNT_W = $clog2(bit_clocks((1 << RATE_W) - 1))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              boundary
);

  logic [CNT_W-1:0] cnt;

  assign boundary = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= CNT_W'(LEAD_CLKS - 1);
    end else if (boundary) begin
      cnt <= CNT_W'(bit_clocks(int'(rate)) - 1);
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/tfs_null_gen.sv
module tfs_null_gen
  import tfs_pkg::*;
#(
  parameter int          GAP_W = 8,
  parameter logic [15:0] SEED  = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic [1:0] mode,
  input  logic       disable_req,
  output logic       live,
  output logic       live_nxt,
  output logic       halted
);

  logic [15:0]      lfsr;
  logic [GAP_W-1:0] gap;
  logic [GAP_W-1:0] mask;
  logic             stop_now;
  logic             pick;

  assign mask     = GAP_W'(gap_mask(int'(mode)));
  assign stop_now = halted | disable_req;
  assign pick     = !stop_now && ((mode == 2'd0) || (gap == '0));
  assign live_nxt = frame_start ? pick : live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr   <= SEED;
      gap    <= '0;
      live   <= 1'b0;
      halted <= 1'b0;
    end else begin
      lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[14] ^ lfsr[12] ^ lfsr[3]};
      if (disable_req) halted <= 1'b1;
      if (frame_start) begin
        live <= pick;
        if (!stop_now && (mode != 2'd0)) begin
          gap <= (gap == '0) ? (lfsr[GAP_W-1:0] & mask) : (gap - 1'b1);
        end
      end
    end
  end

endmodule

// File: rtl/tfs_frame_walk.sv
module tfs_frame_walk
  import tfs_pkg::*;
#(
  parameter int LEN_W     = 4,
  parameter int WORD_W    = 32,
  parameter int BASE_BITS = 32,
  parameter int WIN_BITS  = 8,
  localparam int MAX_BITS = BASE_BITS + 8 * ((1 << LEN_W) - 1),
  localparam int IDX_W    = $clog2(MAX_BITS + 1),
  localparam int OFF_W    = $clog2(WORD_W),
  localparam int PAGE_AW  = IDX_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               boundary,
  input  logic               framing,
  input  logic               stop_val,
  input  logic [LEN_W-1:0]   id_len,
  input  logic               live_nxt,
  input  logic [WORD_W-1:0]  mem_rdata,
  output tfs_phase_e         phase,
  output logic               frame_start,
  output logic [PAGE_AW-1:0] mem_addr,
  output logic               tx_bit,
  output logic               bit_strobe
);

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_n;
  logic [IDX_W-1:0] id_last;
  logic [IDX_W-1:0] look;
  tfs_phase_e       ph_n;
  logic             val_n;

  assign id_last     = IDX_W'(id_bit_count(BASE_BITS, int'(id_len)) - 1);
  assign frame_start = boundary && (phase == PH_WIN) && (idx == IDX_W'(WIN_BITS - 1));

  // Address of the ID bit that will follow the current one
  assign look     = (phase == PH_ID) ? idx + 1'b1 : '0;
  assign mem_addr = look[IDX_W-1:OFF_W];

  always_comb begin
    ph_n  = phase;
    idx_n = idx + 1'b1;
    unique case (phase)
      PH_START: begin
        ph_n  = PH_ID;
        idx_n = '0;
      end
      PH_ID: begin
        if (idx == id_last) begin
          ph_n  = framing ? PH_STOP : PH_WIN;
          idx_n = '0;
        end
      end
      PH_STOP: begin
        ph_n  = PH_WIN;
        idx_n = '0;
      end
      default: begin
        if (idx == IDX_W'(WIN_BITS - 1)) begin
          ph_n  = framing ? PH_START : PH_ID;
          idx_n = '0;
        end
      end
    endcase
  end

  always_comb begin
    unique case (ph_n)
      PH_START: val_n = ~stop_val;
      PH_ID:    val_n = mem_rdata[OFF_W'(WORD_W - 1) - idx_n[OFF_W-1:0]];
      PH_STOP:  val_n = stop_val;
      default:  val_n = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_WIN;
      idx        <= IDX_W'(WIN_BITS - 1);
      tx_bit     <= 1'b0;
      bit_strobe <= 1'b0;
    end else begin
      bit_strobe <= boundary;
      if (boundary) begin
        phase  <= ph_n;
        idx    <= idx_n;
        tx_bit <= val_n & live_nxt;
      end
    end
  end

endmodule

// File: rtl/tag_frame_seq.sv
module tag_frame_seq
  import tfs_pkg::*;
#(
  parameter int          LEN_W     = 4,
  parameter int          RATE_W    = 6,
  parameter int          WORD_W    = 32,
  parameter int          BASE_BITS = 32,
  parameter int          WIN_BITS  = 8,
  parameter int          GAP_W     = 8,
  parameter logic [15:0] SEED      = 16'hACE1,
  localparam int MAX_BITS = BASE_BITS + 8 * ((1 << LEN_W) - 1),
  localparam int IDX_W    = $clog2(MAX_BITS + 1),
  localparam int OFF_W    = $clog2(WORD_W),
  localparam int PAGE_AW  = IDX_W - OFF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LEN_W-1:0]   cfg_id_len,
  input  logic               cfg_framing,
  input  logic               cfg_stop_val,
  input  logic [RATE_W-1:0]  cfg_rate,
  input  logic [1:0]         cfg_null_mode,
  input  logic               disable_req,
  output logic [PAGE_AW-1:0] mem_addr,
  input  logic [WORD_W-1:0]  mem_rdata,
  output logic               tx_bit,
  output logic               bit_strobe,
  output logic               win_open,
  output logic               frame_live
);

  logic       boundary;
  logic       frame_start;
  logic       live;
  logic       live_nxt;
  logic       halted;
  tfs_phase_e phase;

  tfs_bit_timer #(.RATE_W(RATE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rate     (cfg_rate),
    .boundary (boundary)
  );

  tfs_null_gen #(.GAP_W(GAP_W), .SEED(SEED)) u_null (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode        (cfg_null_mode),
    .disable_req (disable_req),
    .live        (live),
    .live_nxt    (live_nxt),
    .halted      (halted)
  );

  tfs_frame_walk #(
    .LEN_W     (LEN_W),
    .WORD_W    (WORD_W),
    .BASE_BITS (BASE_BITS),
    .WIN_BITS  (WIN_BITS)
  ) u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .boundary    (boundary),
    .framing     (cfg_framing),
    .stop_val    (cfg_stop_val),
    .id_len      (cfg_id_len),
    .live_nxt    (live_nxt),
    .mem_rdata   (mem_rdata),
    .phase       (phase),
    .frame_start (frame_start),
    .mem_addr    (mem_addr),
    .tx_bit      (tx_bit),
    .bit_strobe  (bit_strobe)
  );

  assign frame_live = live;
  assign win_open   = live && (phase == PH_WIN);

endmodule

// File: rtl/tfs_checker.sv
module tfs_checker
  import tfs_pkg::*;
#(
  parameter int RATE_W   = 6,
  parameter int PAGE_AW  = 3,
  parameter int MAX_BITS = 152,
  parameter int OFF_W    = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic [RATE_W-1:0]  cfg_rate,
  input logic [PAGE_AW-1:0] mem_addr,
  input logic               tx_bit,
  input logic               bit_strobe,
  input logic               win_open,
  input logic               frame_live,
  input logic               halted,
  input logic               frame_start
);

  logic [11:0] cyc;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc  <= '0;
      seen <= 1'b0;
    end else if (bit_strobe) begin
      cyc  <= 12'd1;
      seen <= 1'b1;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  a_r6_period: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && bit_strobe) |-> (int'(cyc) == int'(bit_clocks(int'(cfg_rate)))));

  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |=> !bit_strobe);

  a_r6_bit_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |-> $stable(tx_bit));

  a_r7_window_in_live: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> frame_live);

  a_r12_silent_low: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_live |-> !tx_bit);

  a_r11_live_at_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_strobe |-> $stable(frame_live));

  a_r10_halt_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && frame_start) |=> !frame_live);

  a_r4_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mem_addr) <= (MAX_BITS >> OFF_W));

endmodule

bind tag_frame_seq tfs_checker #(
  .RATE_W   (RATE_W),
  .PAGE_AW  (PAGE_AW),
  .MAX_BITS (MAX_BITS),
  .OFF_W    (OFF_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_rate    (cfg_rate),
  .mem_addr    (mem_addr),
  .tx_bit      (tx_bit),
  .bit_strobe  (bit_strobe),
  .win_open    (win_open),
  .frame_live  (frame_live),
  .halted      (halted),
  .frame_start (frame_start)
);

// File: tb/tag_frame_seq_tb.sv
module tag_frame_seq_tb;

  typedef struct packed {
    logic [3:0] len;
    logic       fr;
    logic       sv;
    logic [5:0] rate;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{len: 4'd0,  fr: 1'b1, sv: 1'b1, rate: 6'd0},
    '{len: 4'd15, fr: 1'b0, sv: 1'b0, rate: 6'd1},
    '{len: 4'd3,  fr: 1'b1, sv: 1'b0, rate: 6'd2},
    '{len: 4'd1,  fr: 1'b0, sv: 1'b1, rate: 6'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_id_len = '0;
  logic        cfg_framing = 1'b0;
  logic        cfg_stop_val = 1'b0;
  logic [5:0]  cfg_rate = '0;
  logic [1:0]  cfg_null_mode = '0;
  logic        disable_req = 1'b0;
  logic [2:0]  mem_addr;
  logic [31:0] mem_rdata;
  logic        tx_bit, bit_strobe, win_open, frame_live;
  logic [31:0] mem_m [8];

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= mem_m[mem_addr];

  tag_frame_seq u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_id_len    (cfg_id_len),
    .cfg_framing   (cfg_framing),
    .cfg_stop_val  (cfg_stop_val),
    .cfg_rate      (cfg_rate),
    .cfg_null_mode (cfg_null_mode),
    .disable_req   (disable_req),
    .mem_addr      (mem_addr),
    .mem_rdata     (mem_rdata),
    .tx_bit        (tx_bit),
    .bit_strobe    (bit_strobe),
    .win_open      (win_open),
    .frame_live    (frame_live)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int id_bit(input int k);
    return int'(mem_m[k / 32][31 - (k % 32)]);
  endfunction

  task automatic do_reset(input logic [3:0] len, input logic fr, input logic sv,
                          input logic [5:0] rate, input logic [1:0] mode);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_id_len = len; cfg_framing = fr; cfg_stop_val = sv;
    cfg_rate = rate; cfg_null_mode = mode; disable_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "tx_bit in reset", int'(tx_bit), 0);
    chk("R1", "bit_strobe in reset", int'(bit_strobe), 0);
    chk("R1", "win_open in reset", int'(win_open), 0);
    chk("R1", "frame_live in reset", int'(frame_live), 0);
    rst_n = 1'b1;
  endtask

  task automatic next_strobe(input int start, output int gap);
    gap = start;
    do begin
      @(negedge clk);
      gap++;
    end while (!bit_strobe && gap < 5000);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL all: watchdog expired, actual %0d cycles expected fewer", 190000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    vec_t c;
    int   gap, nid, nbits, per, off, etx, ewin, bad, run, silent_tot, live_frames;
    logic cur;
    string tag;

    for (int i = 0; i < 8; i++) mem_m[i] = 32'hA5C30F96 ^ (32'(i) * 32'h13579BDF);

    // Table-driven frame checks (R1-style lead-in, R2..R8, R11)
    for (int v = 0; v < NV; v++) begin
      c = VECS[v];
      do_reset(c.len, c.fr, c.sv, c.rate, 2'd0);
      nid   = 32 + 8 * int'(c.len);
      nbits = nid + (c.fr ? 2 : 0) + 8;
      per   = (int'(c.rate) + 1) * 16;
      next_strobe(0, gap);
      chk("R1", "lead-in clocks", gap, 16);
      for (int f = 0; f < 2; f++) begin
        for (int e = 0; e < nbits; e++) begin
          if (!(f == 0 && e == 0)) begin
            next_strobe(0, gap);
            chk("R6", "bit period", gap, per);
          end
          off = c.fr ? e - 1 : e;
          ewin = 0;
          if (c.fr && e == 0) begin
            etx = int'(!c.sv); tag = "R5";
          end else if (off >= 0 && off < nid) begin
            etx = id_bit(off); tag = "R4";
          end else if (c.fr && off == nid) begin
            etx = int'(c.sv); tag = "R5";
          end else begin
            etx = 0; ewin = 1; tag = "R7";
          end
          chk(tag, "tx_bit", int'(tx_bit), etx);
          chk(c.fr ? "R2" : "R3", "win_open", int'(win_open), ewin);
          chk(f == 0 ? "R11" : "R8", "frame_live", int'(frame_live), 1);
        end
      end
    end

    // Disable request mid-frame (R10, R6 strobe width, R12)
    do_reset(4'd0, 1'b0, 1'b0, 6'd0, 2'd0);
    next_strobe(0, gap);
    @(negedge clk);
    chk("R6", "strobe one clock", int'(bit_strobe), 0);
    next_strobe(1, gap);
    chk("R6", "second bit period", gap, 16);
    for (int e = 2; e <= 10; e++) next_strobe(0, gap);
    disable_req = 1'b1;
    @(negedge clk);
    disable_req = 1'b0;
    bad = 0;
    for (int e = 11; e < 40; e++) begin
      next_strobe(0, gap);
      if (!frame_live || (int'(win_open) != (e >= 32 ? 1 : 0))) bad++;
    end
    chk("R10", "current frame finishes live", bad, 0);
    bad = 0;
    for (int e = 0; e < 120; e++) begin
      next_strobe(0, gap);
      if (frame_live || tx_bit || win_open) bad++;
    end
    chk("R10", "frames after disable silent", bad, 0);
    chk("R12", "silent frame length kept", gap, 16);

    // Random silent frames, mode 1 (R9, R12)
    do_reset(4'd0, 1'b0, 1'b0, 6'd0, 2'd1);
    next_strobe(0, gap);
    chk("R9", "first frame after reset live", int'(frame_live), 1);
    cur = 1'b1; run = 1; bad = 0; silent_tot = 0; live_frames = 0;
    for (int s = 0; s < 4000; s++) begin
      next_strobe(0, gap);
      if (!frame_live && (tx_bit || win_open)) bad++;
      if (frame_live == cur) begin
        run++;
      end else begin
        if (run % 40 != 0) bad++;
        if (!cur) begin
          if (run / 40 > 15) bad++;
          silent_tot += run / 40;
        end else begin
          live_frames += run / 40;
        end
        cur = frame_live;
        run = 1;
      end
    end
    chk("R12", "silent runs whole frames and quiet", bad, 0);
    chk("R9", "silent frames occurred", int'(silent_tot > 0), 1);
    chk("R9", "several live frames", int'(live_frames >= 2), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule